// File: doc/BRIEF.md
# Overlay Output Keying Logic

This block turns per-pixel overlay status into the signals a monitor's video path expects. Each dot clock it takes a character-dot flag, a window flag and a three-bit pixel colour, and registers from them the red, green and blue drives, a fast-blank key and a shared pin. Every tri-state pin is modelled as a data bit plus its own output enable. The fast-blank key has two modes. In the first it keys the overlay over characters and windows. In the second it keys over characters only, so windows are left to the half-tone pin.

The shared pin carries one of two signals. It can carry the half-tone signal, which dims the picture inside a window wherever no dot is lit. It can also carry a clock locked to the line rate, for an external pulse-width modulator. That clock comes from a phase accumulator on the dot clock. Each cycle the accumulator adds twice the wanted number of periods per line (32 in the low-resolution mode, 48 in the high-resolution mode). It wraps modulo the programmed number of dot clocks per line. The accumulator restarts on every falling edge of the negative-going horizontal sync, after that edge passes a synchronizer.

Top module: `ovk_overlay_keying`

## Requirements
- R1: While `rst_n` is low and in the cycle after its release, all output enables are 0 and `tone_clk` is 0.
- R2: With `fb_char_only`=0 and `osd_en`=1, `fbk_oe` and `fbk` are 1 one dot clock after a cycle in which `dot_on` or `win_on` is 1; otherwise `fbk_oe` is 0.
- R3: With `fb_char_only`=1 and `osd_en`=1, `fbk_oe` and `fbk` are 1 one dot clock after a cycle with `dot_on`=1, and `fbk_oe` is 0 after a window-only cycle.
- R4: One dot clock after a cycle with `osd_en`=0, `red_oe`, `green_oe`, `blue_oe` and `fbk_oe` are all 0, whatever the dot and window flags are.
- R5: One dot clock after a cycle with `osd_en`=1, all three colour enables are 1. `{red,green,blue}` equals `pix_rgb[2:0]` (bit 2 red, bit 0 blue) if `dot_on` or `win_on` was 1, and is 0 otherwise.
- R6: With `pwmck_sel`=0, `tone_clk` is 1 one dot clock after a cycle with `osd_en`=1, `win_on`=1 and `dot_on`=0, and is 0 after any other cycle.
- R7: With `pwmck_sel`=1, `res_480`=0 and horizontal sync falling every `line_dots` cycles, `tone_clk` has exactly 32 rising edges in any window of `line_dots` consecutive cycles.
- R8: Under the same conditions with `res_480`=1, `tone_clk` has exactly 48 rising edges in any window of `line_dots` consecutive cycles.
- R9: When `line_dots` is a multiple of twice the period count, every high and every low phase of the line clock lasts exactly `line_dots`/(2×count) cycles.
- R10: A falling edge of `hsync_n` restarts the line clock. Count as edge 1 the first rising clock edge at which `hsync_n` is sampled low. With a two-stage synchronizer, `tone_clk` is 0 after edge `line_dots`/(2×count)+3 and first rises at edge `line_dots`/(2×count)+4.
- R11: With `pwmck_sel`=1, the line clock appears on `tone_clk` even while `osd_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_n | input | 1 | Horizontal sync, active low |
| dot_on | input | 1 | A character or graphic dot is lit at this pixel |
| win_on | input | 1 | This pixel is inside a background window |
| pix_rgb | input | 3 | Pixel colour {red, green, blue} |
| osd_en | input | 1 | Overlay enable |
| fb_char_only | input | 1 | Fast-blank mode: 0 keys characters and windows, 1 keys characters only |
| pwmck_sel | input | 1 | Shared pin select: 0 half-tone, 1 line clock |
| res_480 | input | 1 | Resolution select: 0 gives 32 clock periods per line, 1 gives 48 |
| line_dots | input | CNT_W | Dot clocks per line |
| red | output | 1 | Red drive |
| red_oe | output | 1 | Red output enable |
| green | output | 1 | Green drive |
| green_oe | output | 1 | Green output enable |
| blue | output | 1 | Blue drive |
| blue_oe | output | 1 | Blue output enable |
| fbk | output | 1 | Fast-blank drive |
| fbk_oe | output | 1 | Fast-blank output enable |
| tone_clk | output | 1 | Shared pin: half-tone or line-locked clock |

## Verification
The assertions check some rules on every cycle. The fast-blank pin is only ever driven high, and only while the colour pins are enabled. Half-tone never coincides with a driven fast-blank key in character-only mode. The phase accumulator always stays below the line length it was given. Exact edge counts per line, the width of each clock phase, and the cycle on which the clock first rises after a sync edge depend on a whole line of history. Only the bench's line-long scenarios show those, together with the complete sweep of keying inputs in both fast-blank modes.

// File: rtl/ovk_pkg.sv
package ovk_pkg;

   typedef enum logic {
      FBK_CHAR_OR_WIN = 1'b0,
      FBK_CHAR_ONLY   = 1'b1
   } ovk_fbmode_e;

   typedef struct packed {
      logic       dot;
      logic       win;
      logic [2:0] rgb;
   } ovk_pix_t;

   function automatic logic ovk_key_on(input ovk_pix_t p, input ovk_fbmode_e m);
      return (m == FBK_CHAR_ONLY) ? p.dot : (p.dot | p.win);
   endfunction

endpackage

// File: rtl/ovk_hsync_edge.sv
module ovk_hsync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hsync_n,
   output logic restart
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("ovk_hsync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              prev;

   for (genvar i = 0; i < STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b1;
            else        chain[0] <= hsync_n;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b1;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= chain[LAST];
   end

   assign restart = prev & ~chain[LAST];

endmodule

// File: rtl/ovk_lineclk.sv
module ovk_lineclk #(
   parameter int CNT_W   = 12,
   parameter int MULT_LO = 32,
   parameter int MULT_HI = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             sel_hi,
   input  logic [CNT_W-1:0] line_dots,
   output logic             lclk
);
   localparam int ACC_W   = CNT_W + 1;
   localparam int STEP_LO = 2 * MULT_LO;
   localparam int STEP_HI = 2 * MULT_HI;

   if (MULT_LO < 1 || MULT_HI < 1) begin : g_bad_mult
      $error("ovk_lineclk: period counts must be positive");
   end
   if (STEP_HI >= (1 << CNT_W) || STEP_LO >= (1 << CNT_W)) begin : g_bad_width
      $error("ovk_lineclk: CNT_W too narrow for the period counts");
   end

   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] step;
   logic [ACC_W-1:0] sum;
   logic [ACC_W-1:0] len;
   logic             wrap;

   assign step = sel_hi ? ACC_W'(STEP_HI) : ACC_W'(STEP_LO);
   assign len  = {1'b0, line_dots};
   assign sum  = acc + step;
   assign wrap = (sum >= len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         lclk <= 1'b0;
      end else if (restart) begin
         acc  <= '0;
         lclk <= 1'b0;
      end else if (wrap) begin
         acc  <= sum - len;
         lclk <= ~lclk;
      end else begin
         acc  <= sum;
      end
   end

   // R7 R8: the phase stays inside one line when the line is long enough
   assert_acc_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(acc) < $past(len) && $past(len) >= $past(step)) |-> (acc < $past(len)))
      else $error("accumulator left its line range");

endmodule

// File: rtl/ovk_keyer.sv
module ovk_keyer
   import ovk_pkg::*;
#(
   parameter int NCH = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  ovk_pix_t       pix,
   input  logic           osd_en,
   input  ovk_fbmode_e    fb_mode,
   output logic [NCH-1:0] col_q,
   output logic [NCH-1:0] col_oe_q,
   output logic           fbk_q,
   output logic           fbk_oe_q,
   output logic           tone_d
);
   if (NCH != $bits(pix.rgb)) begin : g_bad_nch
      $error("ovk_keyer: NCH must match the pixel colour width");
   end

   logic paint;
   logic key;

   assign paint  = osd_en & (pix.dot | pix.win);
   assign key    = osd_en & ovk_key_on(pix, fb_mode);
   assign tone_d = osd_en & pix.win & ~pix.dot;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            col_q[ch]    <= 1'b0;
            col_oe_q[ch] <= 1'b0;
         end else begin
            col_q[ch]    <= paint & pix.rgb[ch];
            col_oe_q[ch] <= osd_en;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fbk_q    <= 1'b0;
         fbk_oe_q <= 1'b0;
      end else begin
         fbk_q    <= key;
         fbk_oe_q <= key;
      end
   end

   // R2: the fast-blank pin is only ever driven to its high level
   assert_fbk_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fbk_oe_q |-> fbk_q)
      else $error("fast-blank driven low");

   // R4: fast-blank is driven only while the colour pins are enabled
   assert_fbk_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fbk_oe_q |-> (&col_oe_q))
      else $error("fast-blank driven while overlay off");

endmodule

// File: rtl/ovk_overlay_keying.sv
module ovk_overlay_keying
   import ovk_pkg::*;
#(
   parameter int CNT_W       = 12,
   parameter int MULT_LO     = 32,
   parameter int MULT_HI     = 48,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hsync_n,
   input  logic             dot_on,
   input  logic             win_on,
   input  logic [2:0]       pix_rgb,
   input  logic             osd_en,
   input  logic             fb_char_only,
   input  logic             pwmck_sel,
   input  logic             res_480,
   input  logic [CNT_W-1:0] line_dots,
   output logic             red,
   output logic             red_oe,
   output logic             green,
   output logic             green_oe,
   output logic             blue,
   output logic             blue_oe,
   output logic             fbk,
   output logic             fbk_oe,
   output logic             tone_clk
);
   localparam int NCH = 3;

   ovk_pix_t       pix;
   ovk_fbmode_e    fb_mode;
   logic [NCH-1:0] col_q;
   logic [NCH-1:0] col_oe_q;
   logic           tone_d;
   logic           restart;
   logic           lclk;
   logic           pin_q;

   assign pix     = '{dot: dot_on, win: win_on, rgb: pix_rgb};
   assign fb_mode = fb_char_only ? FBK_CHAR_ONLY : FBK_CHAR_OR_WIN;

   ovk_hsync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .hsync_n (hsync_n),
      .restart (restart)
   );

   ovk_lineclk #(.CNT_W(CNT_W), .MULT_LO(MULT_LO), .MULT_HI(MULT_HI)) u_lclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart),
      .sel_hi    (res_480),
      .line_dots (line_dots),
      .lclk      (lclk)
   );

   ovk_keyer #(.NCH(NCH)) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .pix      (pix),
      .osd_en   (osd_en),
      .fb_mode  (fb_mode),
      .col_q    (col_q),
      .col_oe_q (col_oe_q),
      .fbk_q    (fbk),
      .fbk_oe_q (fbk_oe),
      .tone_d   (tone_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= 1'b0;
      else        pin_q <= pwmck_sel ? lclk : tone_d;
   end

   assign red      = col_q[2];
   assign green    = col_q[1];
   assign blue     = col_q[0];
   assign red_oe   = col_oe_q[2];
   assign green_oe = col_oe_q[1];
   assign blue_oe  = col_oe_q[0];
   assign tone_clk = pin_q;

   // R3 R6: half-tone and a character-only fast-blank key never overlap
   assert_tone_vs_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tone_clk && !$past(pwmck_sel) && $past(fb_char_only)) |-> !fbk_oe)
      else $error("half-tone overlaps character key");

endmodule

// File: tb/sim_ovk_overlay_keying.sv
`timescale 1ns/1ps
module sim_ovk_overlay_keying;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hsync_n = 1'b1;
   logic        dot_on = 1'b0, win_on = 1'b0;
   logic [2:0]  pix_rgb = 3'd0;
   logic        osd_en = 1'b0, fb_char_only = 1'b0, pwmck_sel = 1'b0, res_480 = 1'b0;
   logic [11:0] line_dots = 12'd640;
   logic        red, red_oe, green, green_oe, blue, blue_oe, fbk, fbk_oe, tone_clk;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   ovk_overlay_keying u0 (
      .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .dot_on(dot_on), .win_on(win_on),
      .pix_rgb(pix_rgb), .osd_en(osd_en), .fb_char_only(fb_char_only),
      .pwmck_sel(pwmck_sel), .res_480(res_480), .line_dots(line_dots),
      .red(red), .red_oe(red_oe), .green(green), .green_oe(green_oe),
      .blue(blue), .blue_oe(blue_oe), .fbk(fbk), .fbk_oe(fbk_oe), .tone_clk(tone_clk)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run_clock(input int len, input bit hi, input int n_exp, input int half,
                            input string req_cnt);
      int  rises = 0;
      int  run = 0;
      bit  started = 0;
      bit  prev = 0;
      bit  p;
      res_480   = hi;
      line_dots = 12'(len);
      pwmck_sel = 1'b1;
      osd_en    = 1'b0;
      for (int c = 0; c < 4 * len; c++) begin
         @(negedge clk);
         p = tone_clk;
         hsync_n = ((c % len) < 8) ? 1'b0 : 1'b1;
         if (c >= 2 * len && c < 3 * len && p && !prev) rises++;
         if (half > 0 && c >= 2 * len) begin
            if (p != prev) begin
               if (started) chk("R9 phase length", run, half);
               started = 1;
               run = 1;
            end else begin
               run++;
            end
         end
         prev = p;
      end
      chk(req_cnt, rises, n_exp);
      hsync_n = 1'b1;
   endtask

   initial begin
      #(4.0 * 200000);
      errors++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int exp_oe, exp_rgb, exp_fbk, exp_tone;
      repeat (3) @(negedge clk);
      // R1: state during reset
      chk("R1 colour enables", {red_oe, green_oe, blue_oe}, 0);
      chk("R1 fbk_oe", fbk_oe, 0);
      chk("R1 tone_clk", tone_clk, 0);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R1 after release", {red_oe, green_oe, blue_oe, fbk_oe, tone_clk}, 0);

      // R2 R3 R4 R5 R6: full sweep of keying inputs
      for (int fc = 0; fc < 2; fc++)
         for (int en = 0; en < 2; en++)
            for (int dw = 0; dw < 4; dw++)
               for (int col = 0; col < 8; col++) begin
                  @(negedge clk);
                  fb_char_only = fc[0];
                  osd_en  = en[0];
                  dot_on  = dw[1];
                  win_on  = dw[0];
                  pix_rgb = col[2:0];
                  pwmck_sel = 1'b0;
                  @(posedge clk);
                  @(negedge clk);
                  exp_oe  = en ? 7 : 0;
                  exp_rgb = (en && dw != 0) ? col : 0;
                  exp_fbk = (en && (fc ? dw[1] : (dw != 0))) ? 1 : 0;
                  exp_tone = (en && dw == 1) ? 1 : 0;
                  chk(en ? "R5 colour enables" : "R4 colour enables",
                      {red_oe, green_oe, blue_oe}, exp_oe);
                  if (en) chk("R5 colour value", {red, green, blue}, exp_rgb);
                  chk(!en ? "R4 fbk_oe" : (fc ? "R3 fbk_oe" : "R2 fbk_oe"), fbk_oe, exp_fbk);
                  if (fbk_oe) chk(fc ? "R3 fbk level" : "R2 fbk level", fbk, 1);
                  chk("R6 half-tone", tone_clk, exp_tone);
               end
      dot_on = 1'b0; win_on = 1'b0; osd_en = 1'b0;

      // R7 R8 R9 R11: line clock with overlay off
      run_clock(640, 1'b0, 32, 10, "R7 rises per line 640");
      run_clock(800, 1'b0, 32, 0,  "R7 rises per line 800");
      run_clock(960, 1'b1, 48, 10, "R8 rises per line 960");
      run_clock(1152, 1'b1, 48, 12, "R8 rises per line 1152");
      chk("R11 clock while overlay off", osd_en, 0);

      // R10: restart after a free-running stretch
      res_480 = 1'b0; line_dots = 12'd640; pwmck_sel = 1'b1; hsync_n = 1'b1;
      repeat (237) @(negedge clk);
      hsync_n = 1'b0;
      repeat (13) @(posedge clk);
      @(negedge clk);
      chk("R10 low before first rise", tone_clk, 0);
      @(posedge clk);
      @(negedge clk);
      chk("R10 first rise", tone_clk, 1);
      hsync_n = 1'b1;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule